// File: doc/BRIEF.md
# Ready-Paced Serial Host Controller

This block is the master end of a four-wire serial link to a peripheral that paces the traffic. The peripheral has an active-high ready line. A byte may start only when that line is high. After each byte the peripheral pulls the line low while it works. The controller takes command bytes from a local valid/ready stream and shifts each one out, most significant bit first. The serial clock idles high. Outgoing data changes on the falling clock edge and incoming data is sampled on the rising edge. Whatever the peripheral shifts back during a byte is returned on a response stream. To read a reply, the local side sends the null byte 0x00.

Between bytes the controller waits in three steps. First it waits a fixed guard interval, during which it does not look at the ready line. Then it waits for the ready line, seen through a two-flop synchroniser, to be high. If the response stream is stalled, it also waits until that response has been accepted. After reset, on a local request, or after the ready line has stayed low too long, the controller runs a resynchronisation loop. The loop sends 0x0F, then reads one byte with 0x00, and repeats until the byte read is 0xF0. Only then does it raise `synced` and accept commands. When the link has been idle long enough, an optional timer issues the status command 0x06 by itself.

Back-pressure rules: a command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the link is synced and idle. A response is held, with its data unchanged, until the cycle where `rsp_valid` and `rsp_ready` are both high. No further byte starts until that cycle.

Top module: `rdy_spi_host`

## Requirements
- R1: SCK is high when idle and keeps each level for exactly SCK_HALF clocks. MOSI changes only on a falling SCK edge. MISO is sampled on a rising SCK edge. Bytes are shifted MSB first.
- R2: `spi_ss_n` is low for the whole of each byte and high between bytes. SCK is high whenever `spi_ss_n` is high.
- R3: A byte starts only after `drdy`, passed through a two-flop synchroniser, has been seen high.
- R4: After `spi_ss_n` rises, at least GUARD_CYC clocks pass before it falls again. `drdy` is ignored during that interval.
- R5: After reset and after each `resync_req` pulse, `synced` is low and the controller loops: it sends 0x0F, then sends 0x00 and captures the reply. When the captured byte equals 0xF0, `synced` goes high. `cmd_ready` stays low while `synced` is low.
- R6: Each accepted command byte is sent exactly once, in order. The byte captured during it is returned on `rsp_data` with `rsp_poll` = 0. Sending 0x00 reads one reply byte.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` stay unchanged, `cmd_ready` is low and no byte starts.
- R8: If synchronised `drdy` stays low for TMO_CYC clocks while a byte is waiting, `err_timeout` pulses for one clock. That byte is dropped, `synced` goes low and resynchronisation follows.
- R9: With POLL_EN set and the link synced, once POLL_CYC clocks have passed since the last byte started and no command is pending, the controller sends 0x06 and returns its reply with `rsp_poll` = 1.
- R10: During and right after reset: `spi_ss_n` = 1, `spi_sck` = 1, `spi_mosi` = 0, `synced` = 0, `busy` = 1, `cmd_ready` = 0, `rsp_valid` = 0, `err_timeout` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command byte can be taken |
| cmd_data | input | 8 | Command byte |
| rsp_valid | output | 1 | Response byte held |
| rsp_ready | input | 1 | Local side takes the response |
| rsp_data | output | 8 | Byte captured from MISO |
| rsp_poll | output | 1 | Response belongs to a timer-issued 0x06 |
| resync_req | input | 1 | Pulse to start resynchronisation |
| busy | output | 1 | A byte, a wait or a resync is in progress |
| synced | output | 1 | Resync handshake completed |
| err_timeout | output | 1 | One-clock pulse on a ready-line timeout |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |
| spi_ss_n | output | 1 | Slave select, active low |
| drdy | input | 1 | Asynchronous ready line from the peripheral |

## Verification
Assertions check these relations on every clock:
- SCK is high whenever select is high.
- Select can fall only after the synchronised ready line was high.
- The guard counter is fresh each time a guard interval begins.
- `synced` rises only when the captured byte is 0xF0.
- A timeout leaves the link unsynced.
- A stalled response holds steady.

Other behaviour can only be shown in the bench's scenarios, which run against a peripheral model that answers each byte with the complement of the previous one:
- whole bytes arrive intact with the right bit timing;
- failed acknowledgements make the resync loop repeat;
- a slow ready line stretches the gap between bytes;
- a timeout drops a command;
- a status poll appears after idle time.

// File: rtl/rdy_spi_pkg.sv
package rdy_spi_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] RESYNC_CMD = 8'h0F;
  localparam logic [BYTE_W-1:0] RESYNC_ACK = 8'hF0;
  localparam logic [BYTE_W-1:0] NULL_BYTE  = 8'h00;
  localparam logic [BYTE_W-1:0] POLL_CMD   = 8'h06;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_SHIFT, ST_GUARD, ST_RESP
  } host_state_t;

  typedef enum logic [1:0] {
    K_CMD, K_POLL, K_RS_CMD, K_RS_READ
  } byte_kind_t;
endpackage

// File: rtl/rdy_spi_sync.sv
module rdy_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rdy_spi_shift.sv
module rdy_spi_shift
  import rdy_spi_pkg::*;
#(
  parameter int SCK_HALF = 84
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int HW     = $clog2(SCK_HALF + 1);
  localparam int PHASES = 2 * BYTE_W + 1;
  localparam int PW     = $clog2(PHASES + 1);

  logic [HW-1:0]     hcnt;
  logic [PW-1:0]     phase;
  logic [BYTE_W-1:0] txsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck <= 1'b1; mosi <= 1'b0; ss_n <= 1'b1; done <= 1'b0;
      rx_byte <= '0; hcnt <= '0; phase <= '0; txsr <= '0;
    end else begin
      done <= 1'b0;
      if (start && ss_n) begin
        ss_n  <= 1'b0;
        txsr  <= tx_byte;
        hcnt  <= '0;
        phase <= '0;
      end else if (!ss_n) begin
        if (hcnt == HW'(SCK_HALF - 1)) begin
          hcnt <= '0;
          if (phase == PW'(PHASES - 1)) begin
            ss_n <= 1'b1;
            done <= 1'b1;
            mosi <= 1'b0;
          end else begin
            phase <= phase + 1'b1;
            if (!phase[0]) begin
              sck  <= 1'b0;
              mosi <= txsr[BYTE_W-1];
              txsr <= {txsr[BYTE_W-2:0], 1'b0};
            end else begin
              sck     <= 1'b1;
              rx_byte <= {rx_byte[BYTE_W-2:0], miso};
            end
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  // R2: clock parked high whenever deselected
  a_r2_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> sck);
  // R2: a byte ends only out of a selected period
  a_r2_done_after_select: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!ss_n));
endmodule

// File: rtl/rdy_spi_pace.sv
module rdy_spi_pace #(
  parameter int GUARD_CYC = 10000,
  parameter int TMO_CYC   = 7500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic guard_on,
  input  logic wait_on,
  input  logic drdy_s,
  output logic guard_done,
  output logic drdy_go,
  output logic tmo
);
  localparam int LIM = (GUARD_CYC > TMO_CYC) ? GUARD_CYC : TMO_CYC;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt;

  assign guard_done = guard_on && (cnt == CW'(GUARD_CYC - 1));
  assign drdy_go    = wait_on && drdy_s;
  assign tmo        = wait_on && !drdy_s && (cnt == CW'(TMO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (guard_done || drdy_go || tmo || !(guard_on || wait_on)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R4: every guard interval starts from a cleared count
  a_r4_guard_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(guard_on) |-> (cnt == '0));
endmodule

// File: rtl/rdy_spi_host.sv
module rdy_spi_host
  import rdy_spi_pkg::*;
#(
  parameter int SCK_HALF  = 84,
  parameter int GUARD_CYC = 10000,
  parameter int TMO_CYC   = 7500000,
  parameter bit POLL_EN   = 1'b1,
  parameter int POLL_CYC  = 6250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_data,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       rsp_poll,
  input  logic       resync_req,
  output logic       busy,
  output logic       synced,
  output logic       err_timeout,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_ss_n,
  input  logic       drdy
);
  localparam int PCW = $clog2(POLL_CYC + 1);

  host_state_t       state;
  byte_kind_t        kind;
  logic [BYTE_W-1:0] txb, rxb;
  logic              rs_pend, drdy_s, sh_start, sh_done;
  logic              guard_done, drdy_go, tmo, poll_due;

  rdy_spi_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(drdy), .q_sync(drdy_s));

  rdy_spi_pace #(.GUARD_CYC(GUARD_CYC), .TMO_CYC(TMO_CYC)) u_pace (
    .clk(clk), .rst_n(rst_n),
    .guard_on(state == ST_GUARD), .wait_on(state == ST_WAIT),
    .drdy_s(drdy_s), .guard_done(guard_done), .drdy_go(drdy_go), .tmo(tmo));

  rdy_spi_shift #(.SCK_HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(txb),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .ss_n(spi_ss_n),
    .done(sh_done), .rx_byte(rxb));

  assign sh_start  = (state == ST_WAIT) && drdy_go;
  assign cmd_ready = (state == ST_IDLE) && !rs_pend && synced;
  assign busy      = (state != ST_IDLE) || rs_pend;

  generate
    if (POLL_EN) begin : g_poll
      logic [PCW-1:0] pcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     pcnt <= '0;
        else if (!synced || sh_start)   pcnt <= '0;
        else if (pcnt != PCW'(POLL_CYC - 1)) pcnt <= pcnt + 1'b1;
      end
      assign poll_due = synced && (pcnt == PCW'(POLL_CYC - 1));
    end else begin : g_no_poll
      assign poll_due = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; kind <= K_RS_CMD; txb <= '0;
      synced <= 1'b0; rs_pend <= 1'b1; err_timeout <= 1'b0;
      rsp_valid <= 1'b0; rsp_data <= '0; rsp_poll <= 1'b0;
    end else begin
      err_timeout <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (rs_pend) begin
            rs_pend <= 1'b0; synced <= 1'b0;
            kind <= K_RS_CMD; txb <= RESYNC_CMD; state <= ST_WAIT;
          end else if (cmd_valid && cmd_ready) begin
            kind <= K_CMD; txb <= cmd_data; state <= ST_WAIT;
          end else if (poll_due) begin
            kind <= K_POLL; txb <= POLL_CMD; state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tmo) begin
            err_timeout <= 1'b1; synced <= 1'b0; rs_pend <= 1'b1;
            state <= ST_IDLE;
          end else if (drdy_go) begin
            state <= ST_SHIFT;
          end
        end
        ST_SHIFT: if (sh_done) state <= ST_GUARD;
        ST_GUARD: begin
          if (guard_done) begin
            unique case (kind)
              K_RS_CMD: begin
                kind <= K_RS_READ; txb <= NULL_BYTE; state <= ST_WAIT;
              end
              K_RS_READ: begin
                if (rxb == RESYNC_ACK) begin
                  synced <= 1'b1; state <= ST_IDLE;
                end else begin
                  kind <= K_RS_CMD; txb <= RESYNC_CMD; state <= ST_WAIT;
                end
              end
              default: begin
                rsp_valid <= 1'b1; rsp_data <= rxb;
                rsp_poll <= (kind == K_POLL); state <= ST_RESP;
              end
            endcase
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0; state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (resync_req) rs_pend <= 1'b1;
    end
  end

  // R3: select falls only after the synchronised ready line was high
  a_r3_start_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_ss_n) |-> $past(drdy_s));
  // R5: link declared synced only on the acknowledge byte
  a_r5_sync_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> (rxb == RESYNC_ACK));
  // R7: stalled response is held unchanged
  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_poll)));
  // R8: a timeout leaves the link unsynced
  a_r8_tmo_unsync: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> !synced);
endmodule

// File: tb/rdy_spi_host_test.sv
`timescale 1ns/1ps
module rdy_spi_host_test;
  localparam int HALF = 3, GUARD = 20, TMO = 400, POLL = 3000;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, rsp_ready = 1, resync_req = 0, miso = 0, drdy;
  logic [7:0] cmd_data = 0;
  logic cmd_ready, rsp_valid, rsp_poll, busy, synced, err_timeout;
  logic sck, mosi, ss_n;
  logic [7:0] rsp_data;

  always #2 clk = ~clk;

  rdy_spi_host #(.SCK_HALF(HALF), .GUARD_CYC(GUARD), .TMO_CYC(TMO),
                 .POLL_EN(1'b1), .POLL_CYC(POLL)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_poll(rsp_poll), .resync_req(resync_req),
    .busy(busy), .synced(synced), .err_timeout(err_timeout),
    .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso), .spi_ss_n(ss_n), .drdy(drdy));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- peripheral model ----------------
  int slave_busy = 10, busy_cnt = 0, corrupt_left = 2, r0f_count = 0;
  bit force_low = 0, byte_open = 0, run_at_start = 0;
  logic [7:0] s_in, s_out, s_sent, next_out = 8'hFF;
  logic [7:0] xin_q[$], xout_q[$], cmd_q[$];

  assign drdy = !force_low && (busy_cnt == 0);

  always @(negedge ss_n) begin
    byte_open = 1; s_in = 0; s_out = next_out; s_sent = next_out;
    run_at_start = synced;
  end
  always @(negedge sck) if (ss_n === 1'b0) begin
    miso <= s_out[7]; s_out = {s_out[6:0], 1'b0};
  end
  always @(posedge sck) if (ss_n === 1'b0) s_in = {s_in[6:0], mosi};
  always @(posedge ss_n) if (byte_open) begin
    byte_open = 0;
    if (run_at_start) begin xin_q.push_back(s_in); xout_q.push_back(s_sent); end
    else if (s_in == 8'h0F) r0f_count++;
    if (s_in == 8'h0F && corrupt_left > 0) begin next_out = 8'h33; corrupt_left--; end
    else next_out = ~s_in;
  end

  // ---------------- per-clock reference monitor ----------------
  logic prev_ss = 1, prev_sck = 1, prev_valid = 0, prev_ready = 0;
  logic [7:0] prev_data = 0;
  logic [3:0] drdy_hist = 0;
  int run = 0, gap = 1000, rsp_seen = 0, poll_seen = 0, tmo_seen = 0;

  always @(negedge clk) begin
    if (ss_n && !prev_ss) busy_cnt <= slave_busy;
    else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (rst_n) begin
      check(!ss_n || sck, "R2 sck high while deselected", sck, 1);
      if (!ss_n && prev_ss) begin
        check(|drdy_hist, "R3 start after ready high", drdy_hist, 1);
        check(gap >= GUARD, "R4 guard gap", gap, GUARD);
        run = 1;
      end else if (!ss_n && sck != prev_sck) begin
        check(run == HALF, "R1 sck half period", run, HALF);
        run = 1;
      end else run++;
      gap = ss_n ? gap + 1 : 0;
      if (prev_valid && !prev_ready)
        check(rsp_valid && rsp_data == prev_data, "R7 response held", rsp_data, prev_data);
      if (prev_valid && !prev_ready)
        check(prev_ss == 1 || ss_n == prev_ss, "R7 no byte while stalled", ss_n, prev_ss);
      if (rsp_valid && rsp_ready) begin
        rsp_seen++;
        if (xin_q.size() == 0) check(0, "R6 response without byte", 0, 1);
        else begin
          logic [7:0] bi, bo;
          bi = xin_q.pop_front(); bo = xout_q.pop_front();
          check(rsp_data == bo, "R6 reply data", rsp_data, bo);
          if (rsp_poll) begin
            poll_seen++;
            check(bi == 8'h06, "R9 poll command byte", bi, 8'h06);
          end else if (cmd_q.size() == 0) check(0, "R6 unexpected command", bi, 0);
          else begin
            logic [7:0] ec;
            ec = cmd_q.pop_front();
            check(bi == ec, "R6 command byte on MOSI", bi, ec);
          end
        end
      end
      if (err_timeout) begin
        tmo_seen++;
        if (cmd_q.size() > 0) void'(cmd_q.pop_back());
      end
    end
    prev_ss = ss_n; prev_sck = sck; prev_valid = rsp_valid;
    prev_ready = rsp_ready; prev_data = rsp_data;
    drdy_hist = {drdy_hist[2:0], drdy};
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [7:0] b);
    @(posedge clk); #1; cmd_valid = 1; cmd_data = b;
    do @(negedge clk); while (!cmd_ready);
    cmd_q.push_back(b);
    @(posedge clk); #1; cmd_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || rsp_valid);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int n0, s0, t0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(ss_n && sck && !mosi, "R10 serial pins idle", {ss_n, sck, mosi}, 3'b110);
    check(!synced && busy, "R10 unsynced and busy", {synced, busy}, 2'b01);
    check(!cmd_ready && !rsp_valid && !err_timeout, "R10 streams quiet",
          {cmd_ready, rsp_valid, err_timeout}, 0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    check(!synced && !cmd_ready, "R10 unsynced after release", {synced, cmd_ready}, 0);

    // R5: two bad acknowledges, third good
    do @(negedge clk); while (!synced);
    check(r0f_count == 3, "R5 resync attempts", r0f_count, 3);
    check(cmd_ready, "R5 commands accepted once synced", cmd_ready, 1);

    // R6 and R1: plain commands and reads
    send(8'h12); send(8'h00); send(8'h00); send(8'hA5);
    wait_idle();
    check(rsp_seen == 4, "R6 response count", rsp_seen, 4);

    // R7: back-pressure
    @(posedge clk); #1; rsp_ready = 0;
    send(8'h5A);
    do @(negedge clk); while (!rsp_valid);
    n0 = rsp_seen;
    @(posedge clk); #1; cmd_valid = 1; cmd_data = 8'hC3;
    repeat (200) @(negedge clk);
    check(!cmd_ready && rsp_valid, "R7 stalled: no new command", cmd_ready, 0);
    check(xin_q.size() == 1, "R7 only one byte sent", xin_q.size(), 1);
    @(posedge clk); #1; rsp_ready = 1;
    do @(negedge clk); while (!cmd_ready);
    cmd_q.push_back(8'hC3);
    @(posedge clk); #1; cmd_valid = 0;
    wait_idle();
    check(rsp_seen == n0 + 2, "R7 both responses delivered", rsp_seen, n0 + 2);

    // R4: slow ready line after each byte
    slave_busy = 300;
    send(8'h3C); send(8'h00);
    wait_idle();
    check(tmo_seen == 0 && synced, "R4 slow ready tolerated", tmo_seen, 0);
    slave_busy = 10;

    // R8: ready held low past the limit
    @(posedge clk); #1; force_low = 1;
    send(8'h77);
    repeat (TMO + 50) @(negedge clk);
    check(tmo_seen >= 1, "R8 timeout flagged", tmo_seen, 1);
    check(!synced && !cmd_ready, "R8 link dropped", synced, 0);
    @(posedge clk); #1; force_low = 0;
    do @(negedge clk); while (!synced);
    check(cmd_q.size() == 0, "R8 command dropped", cmd_q.size(), 0);
    send(8'h81); wait_idle();

    // R5: requested resync
    s0 = r0f_count;
    @(posedge clk); #1; resync_req = 1;
    @(posedge clk); #1; resync_req = 0;
    repeat (3) @(negedge clk);
    check(!synced, "R5 resync request clears synced", synced, 0);
    do @(negedge clk); while (!synced);
    check(r0f_count == s0 + 1, "R5 one resync pass", r0f_count, s0 + 1);

    // R9: idle poll
    t0 = poll_seen;
    repeat (POLL + 400) @(negedge clk);
    wait_idle();
    check(poll_seen == t0 + 1, "R9 poll issued once", poll_seen, t0 + 1);
    check(xin_q.size() == 0, "R9 no stray bytes", xin_q.size(), 0);

    finished = 1;
    finish_run();
  end
endmodule